// File: doc/BRIEF.md
# Coprocessor Bank Mapper and Launch Gate

This block serves a program-executing coprocessor. It translates an 8-bit bank number into a physical byte offset inside either the ROM or the RAM image, and it flags which of the two devices the offset addresses. The same request also decides whether the coprocessor may start running at the requested bank and program counter. That decision depends on which bank region is addressed, on the access grants in the mode register, and on whether the program counter falls inside the active instruction cache window.

A request is a one-cycle pulse on `req`, sampled while the block is idle. The block registers the decision at that point. It then reduces the bank by repeated subtraction, so no divider is built. The wait depends on the quotient and never exceeds 128 cycles. Completion is a one-cycle `done` pulse. The offset, the RAM select and the launch verdict are updated in that same cycle. With `done` comes either a go-clear pulse (launch refused) or an interrupt-clear pulse (launch accepted). The memories themselves sit outside the block.

Top module: `bank_start_gate`

## Requirements
- R1: After reset `busy`, `done`, `start_ok`, `go_clr` and `irq_clr` are 0 and `phys_off` is 0.
- R2: ROM mapping works on the bank with bit 7 cleared (b = bank & 0x7F). When b >= 0x40 the result is `phys_off` = (b mod N) << 16 with `ram_sel` = 0, where N is the effective ROM bank count. For example, banks 0x45 and 0xC5 map alike.
- R3: When N is 1, a bank with b >= 0x40 maps to (b & 1) << 16.
- R4: When b < 0x40 the result is `phys_off` = ((b mod 2N) << 16) + 0x200000 with `ram_sel` = 0.
- R5: Unreduced banks 0x70 to 0x73 map to RAM: `phys_off` = ((bank & 3) mod M) << 16 and `ram_sel` = 1, where M is the RAM bank count. Banks 0xF0 to 0xF3 are not RAM and follow R2.
- R6: A ROM bank count above 32 is treated as 32. A ROM or RAM bank count of 0 is treated as 1.
- R7: When `cache_hit` is 1 the launch is always permitted.
- R8: When `cache_hit` is 0 the launch is refused in three cases: the bank is below 0x40 and `pc` is below 0x8000; the bank is in 0x60 to 0x6F; or the bank is 0x74 or above.
- R9: In all other cases the launch requires `ram_grant` (mode bit 3) for banks 0x70 to 0x73, and `rom_grant` (mode bit 4) for any other bank.
- R10: `done` is a one-cycle pulse. In that cycle exactly one of `go_clr` (refused) or `irq_clr` (permitted) is high. `start_ok` shows the verdict and holds it until the next completion.
- R11: Let the request edge be edge 0 and let q be the quotient of the reduction. Then `done` is high after edge q+1, with q+1 <= 128. `busy` is high from edge 0 until `done` rises. A `req` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse, taken when idle |
| bank | input | 8 | Bank number to map and check |
| pc | input | 16 | Program counter for the launch check |
| rom_banks | input | 8 | Installed ROM bank count |
| ram_banks | input | 8 | Installed RAM bank count |
| rom_grant | input | 1 | Mode bit 4: ROM execution allowed |
| ram_grant | input | 1 | Mode bit 3: RAM execution allowed |
| cache_hit | input | 1 | PC lies in the active cache window |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| phys_off | output | 24 | Physical byte offset |
| ram_sel | output | 1 | 1 when the offset addresses RAM |
| start_ok | output | 1 | Registered launch verdict |
| go_clr | output | 1 | Pulse: clear the go flag |
| irq_clr | output | 1 | Pulse: clear the interrupt flag |

## Verification
The hardest conditions to reach from the ports are the long reductions and the overlaps between rules. A long reduction pairs a large bank with a small divisor. The overlaps are an aliased bank such as 0xF1, whose low bits match a RAM bank but which must be mapped as ROM, and a ROM count above 32, where clamping changes the remainder. The bench drives each of these on purpose, for example bank 0x7F with two ROM banks so the reduction runs long. It predicts the exact number of cycles to completion from the quotient. While the block is busy it fires a second request carrying different inputs, then checks that the result still belongs to the first request.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;
  typedef enum logic [1:0] {
    REG_ROM_HI = 2'd0,
    REG_ROM_LO = 2'd1,
    REG_RAM    = 2'd2
  } region_e;
endpackage

// File: rtl/bank_region_decode.sv
module bank_region_decode
  import bank_gate_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int PC_W    = 16,
  parameter int CNT_W   = 8,
  parameter int ROM_MAX = 32
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [PC_W-1:0]   pc,
  input  logic [CNT_W-1:0]  rom_banks,
  input  logic [CNT_W-1:0]  ram_banks,
  input  logic              rom_grant,
  input  logic              ram_grant,
  input  logic              cache_hit,
  output region_e           region,
  output logic [CNT_W-1:0]  dividend,
  output logic [CNT_W-1:0]  divisor,
  output logic              permit
);
  localparam logic [BANK_W-1:0] RED_MASK  = BANK_W'(8'h7F);
  localparam logic [BANK_W-1:0] HI_START  = BANK_W'(8'h40);
  localparam logic [BANK_W-1:0] RAM_FIRST = BANK_W'(8'h70);
  localparam logic [BANK_W-1:0] RAM_LAST  = BANK_W'(8'h73);
  localparam logic [BANK_W-1:0] HOLE_LO   = BANK_W'(8'h60);
  localparam logic [BANK_W-1:0] HOLE_HI   = BANK_W'(8'h6F);
  localparam logic [BANK_W-1:0] TOP_DENY  = BANK_W'(8'h74);
  localparam logic [PC_W-1:0]   PC_HALF   = PC_W'(1) << (PC_W - 1);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0]  ROM_LIM   = CNT_W'(ROM_MAX);

  logic [BANK_W-1:0] b_red;
  logic [CNT_W-1:0]  rom_eff, ram_eff;
  logic              is_ram;

  always_comb begin
    b_red   = bank & RED_MASK;
    is_ram  = (bank >= RAM_FIRST) && (bank <= RAM_LAST);
    rom_eff = (rom_banks == '0) ? ONE : ((rom_banks > ROM_LIM) ? ROM_LIM : rom_banks);
    ram_eff = (ram_banks == '0) ? ONE : ram_banks;

    if (is_ram) begin
      region   = REG_RAM;
      dividend = CNT_W'(bank[1:0]);
      divisor  = ram_eff;
    end else if (b_red >= HI_START) begin
      region   = REG_ROM_HI;
      dividend = CNT_W'(b_red);
      divisor  = (rom_eff == ONE) ? CNT_W'(2) : rom_eff;
    end else begin
      region   = REG_ROM_LO;
      dividend = CNT_W'(b_red);
      divisor  = rom_eff << 1;
    end

    if (cache_hit)                                  permit = 1'b1;
    else if ((bank < HI_START) && (pc < PC_HALF))   permit = 1'b0;
    else if ((bank >= HOLE_LO) && (bank <= HOLE_HI)) permit = 1'b0;
    else if (bank >= TOP_DENY)                      permit = 1'b0;
    else if (is_ram)                                permit = ram_grant;
    else                                            permit = rom_grant;
  end
endmodule

// File: rtl/seq_remainder.sv
module seq_remainder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          running,
  output logic          rdy,
  output logic [DW-1:0] rem
);
  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      rem     <= '0;
      div_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      rem     <= dividend;
      div_q   <= divisor;
    end else if (running) begin
      if (rem >= div_q) rem <= rem - div_q;
      else running <= 1'b0;
    end
  end

  assign rdy = running && (rem < div_q);
endmodule

// File: rtl/bank_start_gate.sv
module bank_start_gate
  import bank_gate_pkg::*;
#(
  parameter int BANK_W     = 8,
  parameter int PC_W       = 16,
  parameter int CNT_W      = 8,
  parameter int BANK_SHIFT = 16,
  parameter int ROM_MAX    = 32,
  parameter int OFF_W      = CNT_W + BANK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [BANK_W-1:0] bank,
  input  logic [PC_W-1:0]   pc,
  input  logic [CNT_W-1:0]  rom_banks,
  input  logic [CNT_W-1:0]  ram_banks,
  input  logic              rom_grant,
  input  logic              ram_grant,
  input  logic              cache_hit,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  phys_off,
  output logic              ram_sel,
  output logic              start_ok,
  output logic              go_clr,
  output logic              irq_clr
);
  localparam logic [OFF_W-1:0] LOW_BASE = OFF_W'(1) << (BANK_SHIFT + 5);

  region_e          region_c, region_q;
  logic [CNT_W-1:0] dvd, dvs, rem;
  logic             permit_c, permit_q;
  logic             running, rdy, accept;
  logic [OFF_W-1:0] base_off;

  bank_region_decode #(
    .BANK_W(BANK_W), .PC_W(PC_W), .CNT_W(CNT_W), .ROM_MAX(ROM_MAX)
  ) u_decode (
    .bank(bank), .pc(pc), .rom_banks(rom_banks), .ram_banks(ram_banks),
    .rom_grant(rom_grant), .ram_grant(ram_grant), .cache_hit(cache_hit),
    .region(region_c), .dividend(dvd), .divisor(dvs), .permit(permit_c)
  );

  assign accept = req && !running;

  seq_remainder #(.DW(CNT_W)) u_rem (
    .clk(clk), .rst(rst), .start(accept), .dividend(dvd), .divisor(dvs),
    .running(running), .rdy(rdy), .rem(rem)
  );

  assign busy     = running;
  assign base_off = OFF_W'(rem) << BANK_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= REG_ROM_HI;
      permit_q <= 1'b0;
      done     <= 1'b0;
      phys_off <= '0;
      ram_sel  <= 1'b0;
      start_ok <= 1'b0;
      go_clr   <= 1'b0;
      irq_clr  <= 1'b0;
    end else begin
      if (accept) begin
        region_q <= region_c;
        permit_q <= permit_c;
      end
      done    <= rdy;
      go_clr  <= rdy && !permit_q;
      irq_clr <= rdy && permit_q;
      if (rdy) begin
        start_ok <= permit_q;
        ram_sel  <= (region_q == REG_RAM);
        phys_off <= (region_q == REG_ROM_LO) ? base_off + LOW_BASE : base_off;
      end
    end
  end
endmodule

// File: rtl/bank_start_gate_chk.sv
module bank_start_gate_chk #(
  parameter int OFF_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             busy,
  input logic             done,
  input logic [OFF_W-1:0] phys_off,
  input logic             start_ok,
  input logic             go_clr,
  input logic             irq_clr
);
  logic [7:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 8'd1;
  end

  assert_busy_after_req_R11: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);
  assert_latency_bound_R11: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= 8'd128);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (go_clr ^ irq_clr));
  assert_clr_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    (go_clr || irq_clr) |-> done);
  assert_verdict_match_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (start_ok == irq_clr));
  assert_off_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(phys_off) && $stable(start_ok)));
  assert_bank_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    phys_off[15:0] == 16'h0);
endmodule

bind bank_start_gate bank_start_gate_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .done(done),
  .phys_off(phys_off), .start_ok(start_ok), .go_clr(go_clr), .irq_clr(irq_clr)
);

// File: tb/bank_start_gate_bench.sv
`timescale 1ns/1ps
module bank_start_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [7:0]  bank = '0;
  logic [15:0] pc = '0;
  logic [7:0]  rom_banks = 8'd1, ram_banks = 8'd1;
  logic        rom_grant = 1'b0, ram_grant = 1'b0, cache_hit = 1'b0;
  logic        busy, done, ram_sel, start_ok, go_clr, irq_clr;
  logic [23:0] phys_off;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  bank_start_gate u_bank_start_gate (
    .clk(clk), .rst(rst), .req(req), .bank(bank), .pc(pc),
    .rom_banks(rom_banks), .ram_banks(ram_banks), .rom_grant(rom_grant),
    .ram_grant(ram_grant), .cache_hit(cache_hit), .busy(busy), .done(done),
    .phys_off(phys_off), .ram_sel(ram_sel), .start_ok(start_ok),
    .go_clr(go_clr), .irq_clr(irq_clr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_rom(input int r);
    if (r == 0) return 1;
    if (r > 32) return 32;
    return r;
  endfunction

  // Expected results from the requirements
  task automatic model(input int b, input int p, input int rc, input int mc,
                       input bit rg, input bit mg, input bit hit,
                       output int off, output bit isram, output bit ok, output int q);
    int red, n, m, dv, dd;
    red = b & 8'h7F;
    n = eff_rom(rc);
    m = (mc == 0) ? 1 : mc;
    isram = (b >= 8'h70 && b <= 8'h73);
    if (isram) begin dd = b & 3; dv = m; off = (dd % dv) << 16; end
    else if (red >= 8'h40) begin
      dd = red; dv = (n == 1) ? 2 : n;
      off = (n == 1) ? ((red & 1) << 16) : ((red % n) << 16);
    end else begin dd = red; dv = 2 * n; off = ((red % (2 * n)) << 16) + 32'h200000; end
    q = dd / dv;
    if (hit) ok = 1;
    else if (b < 8'h40 && p < 16'h8000) ok = 0;
    else if (b >= 8'h60 && b <= 8'h6F) ok = 0;
    else if (b >= 8'h74) ok = 0;
    else if (isram) ok = mg;
    else ok = rg;
  endtask

  task automatic run(input string tag, input int b, input int p, input int rc,
                     input int mc, input bit rg, input bit mg, input bit hit,
                     input bit chk_lat);
    int off, q, lat;
    bit isram, ok;
    model(b, p, rc, mc, rg, mg, hit, off, isram, ok, q);
    @(negedge clk);
    bank = 8'(b); pc = 16'(p); rom_banks = 8'(rc); ram_banks = 8'(mc);
    rom_grant = rg; ram_grant = mg; cache_hit = hit; req = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check({tag, " off"}, 32'(phys_off), 32'(off));
    check({tag, " ram_sel"}, 32'(ram_sel), 32'(isram));
    check({tag, " start_ok"}, 32'(start_ok), 32'(ok));
    check({tag, " go_clr R10"}, 32'(go_clr), 32'(!ok));
    check({tag, " irq_clr R10"}, 32'(irq_clr), 32'(ok));
    if (chk_lat) check({tag, " latency R11"}, 32'(lat), 32'(q + 2));
    @(negedge clk);
    check({tag, " done pulse R10"}, 32'(done), 32'd0);
    check({tag, " verdict held R10"}, 32'(start_ok), 32'(ok));
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 start_ok", 32'(start_ok), 0);
    check("R1 go_clr", 32'(go_clr), 0);
    check("R1 irq_clr", 32'(irq_clr), 0);
    check("R1 phys_off", 32'(phys_off), 0);
  endtask

  task automatic t_rom_high;
    run("R2 0x45", 8'h45, 16'h8000, 4, 1, 1, 0, 0, 1);
    run("R2 0xC5 alias", 8'hC5, 16'h8000, 4, 1, 1, 0, 0, 1);
    run("R2 0xF1 not RAM R5", 8'hF1, 16'h8000, 5, 2, 1, 1, 0, 1);
  endtask

  task automatic t_single_rom;
    run("R3 odd", 8'h47, 16'h9000, 1, 1, 1, 0, 0, 1);
    run("R3 even", 8'h46, 16'h9000, 1, 1, 1, 0, 0, 1);
  endtask

  task automatic t_rom_low;
    run("R4 0x05", 8'h05, 16'h8000, 2, 1, 1, 0, 0, 1);
    run("R4 0x3F", 8'h3F, 16'hFFFF, 3, 1, 1, 0, 0, 1);
  endtask

  task automatic t_ram;
    run("R5 0x71", 8'h71, 16'h0000, 4, 2, 0, 1, 0, 1);
    run("R5 0x73", 8'h73, 16'h0000, 4, 3, 0, 1, 0, 1);
  endtask

  task automatic t_clamp;
    run("R6 clamp", 8'h65, 16'h8000, 8'h40, 1, 1, 0, 0, 1);
    run("R6 rom zero", 8'h47, 16'h8000, 0, 0, 1, 0, 0, 1);
    run("R6 ram zero", 8'h72, 16'h8000, 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_permit;
    run("R8 low pc", 8'h20, 16'h1000, 2, 1, 1, 1, 0, 0);
    run("R8 low ok R9", 8'h20, 16'h8000, 2, 1, 1, 0, 0, 0);
    run("R8 hole", 8'h65, 16'h8000, 2, 1, 1, 1, 0, 0);
    run("R8 top", 8'h74, 16'h8000, 2, 1, 1, 1, 0, 0);
    run("R8 high top", 8'hC0, 16'h8000, 2, 1, 1, 1, 0, 0);
    run("R9 ram no grant", 8'h70, 16'h8000, 2, 1, 1, 0, 0, 0);
    run("R9 ram grant", 8'h70, 16'h8000, 2, 1, 0, 1, 0, 0);
    run("R9 rom no grant", 8'h40, 16'h8000, 2, 1, 0, 1, 0, 0);
    run("R7 hit hole", 8'h65, 16'h0000, 2, 1, 0, 0, 1, 0);
    run("R7 hit low", 8'h10, 16'h0100, 2, 1, 0, 0, 1, 0);
  endtask

  task automatic t_busy_ignore;
    int off, q, lat;
    bit isram, ok;
    model(8'h7F, 16'h8000, 2, 1, 1, 0, 0, off, isram, ok, q);
    @(negedge clk);
    bank = 8'h7F; pc = 16'h8000; rom_banks = 8'd2; ram_banks = 8'd1;
    rom_grant = 1'b1; ram_grant = 1'b0; cache_hit = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    check("R11 busy during run", 32'(busy), 1);
    bank = 8'h05; rom_banks = 8'd7; req = 1'b1;
    @(negedge clk); lat++;
    req = 1'b0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check("R11 long latency", 32'(lat), 32'(q + 2));
    check("R11 ignored req off", 32'(phys_off), 32'(off));
    check("R11 ignored req ok", 32'(start_ok), 32'(ok));
    repeat (3) @(negedge clk);
    check("R11 no second result", 32'(busy), 0);
    check("R11 offset kept", 32'(phys_off), 32'(off));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rom_high();
        t_single_rom();
        t_rom_low();
        t_ram();
        t_clamp();
        t_permit();
        t_busy_ignore();
      end
      begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule